// File: doc/BRIEF.md
# Repeating Loop Code Generator

This block drives a serial transmit bit stream that either carries ordinary line data or, when enabled, a short programmable bit pattern repeated without end. It serves for in-band loopback signalling on a T1/E1 line: the far end recognises the repeating pattern and then opens or closes a loop. The code is supplied as an upper and a lower byte. A two-bit selector picks the pattern length. One new bit leaves the block on every cycle in which the bit-rate clock enable is high.

The pattern is read from the top bit of the upper byte downward. For short lengths only the leading bits of the upper byte are used. For the full sixteen-bit length the upper byte and then the lower byte are walked. A length of 1, 2, 4 or 8 bits is made by repeating the code across all sixteen bits and selecting sixteen. A burst always opens at the first pattern bit. Changes to the code or the length made during a burst are held back until the current pattern ends, so the line never sees a truncated pattern.

Top module: `lc_loop_code_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tx_out` is 0.
- R2: `len_sel` gives the pattern length: 2'b00 = 5 bits, 2'b01 = 6 bits, 2'b10 = 7 bits, 2'b11 = 16 bits.
- R3: Pattern bit k (k = 0 first) is bit 7-k of `code_hi` for k < 8 and bit 15-k of `code_lo` for k >= 8. With `code_hi` = 8'h80 and length 5, the stream is 1,0,0,0,0 repeated.
- R4: For lengths 5, 6 and 7, `code_lo` has no effect on `tx_out`.
- R5: With length 16, all sixteen code bits are sent in order before the pattern repeats.
- R6: `tx_out` changes only in the cycle after one in which `bit_en` is 1. Otherwise it holds its value.
- R7: The first enabled bit after a sample with `tx_enable` low (or after reset) is pattern bit 0, which is `code_hi[7]`.
- R8: Changes to `code_hi`, `code_lo` or `len_sel` during a burst take effect only at the start of the next pattern repetition.
- R9: When `tx_enable` is 0 at a `bit_en` cycle, `tx_out` in the next cycle equals the `bypass_in` of that cycle. This is the same one-cycle latency as the pattern path.
- R10: `tx_enable` is sampled only on `bit_en` cycles. Dropping it mid-pattern switches to bypass data at the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bit-rate clock enable; one output bit per high cycle |
| tx_enable | input | 1 | 1 sends the loop pattern, 0 passes bypass data |
| code_hi | input | 8 | Upper code byte; its MSB is sent first |
| code_lo | input | 8 | Lower code byte; used only at length 16 |
| len_sel | input | 2 | Pattern length select |
| bypass_in | input | 1 | Normal line data used when the pattern is off |
| tx_out | output | 1 | Registered transmit bit |

## Verification
Two events can land on the same `bit_en` cycle: the last bit of a pattern repetition and a change of code or length. A third can join them: `tx_enable` falling as the pattern wraps. The bench changes `len_sel`, `code_hi` and `code_lo` on random bits, including the exact wrap bit. It judges every output bit against a bench model in which the change is adopted only after the wrap. A torn pattern or an early adoption therefore shows up as a mismatched bit.

// File: rtl/lc_pkg.sv
package lc_pkg;

   typedef enum logic [1:0] {
      LSEL_FIVE    = 2'b00,
      LSEL_SIX     = 2'b01,
      LSEL_SEVEN   = 2'b10,
      LSEL_SIXTEEN = 2'b11
   } lsel_e;

   localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/lc_len_decode.sv
module lc_len_decode
   import lc_pkg::*;
#(
   parameter int unsigned CODE_W = 16,
   parameter int unsigned LEN_A  = 5,
   parameter int unsigned LEN_B  = 6,
   parameter int unsigned LEN_C  = 7,
   parameter int unsigned LEN_D  = 16,
   localparam int unsigned IDX_W = $clog2(CODE_W)
) (
   input  logic [SEL_W-1:0] sel,
   output logic [IDX_W-1:0] last_idx
);

   localparam logic [IDX_W-1:0] LAST_A = IDX_W'(LEN_A - 1);
   localparam logic [IDX_W-1:0] LAST_B = IDX_W'(LEN_B - 1);
   localparam logic [IDX_W-1:0] LAST_C = IDX_W'(LEN_C - 1);
   localparam logic [IDX_W-1:0] LAST_D = IDX_W'(LEN_D - 1);

   always_comb begin
      unique case (lsel_e'(sel))
         LSEL_FIVE:    last_idx = LAST_A;
         LSEL_SIX:     last_idx = LAST_B;
         LSEL_SEVEN:   last_idx = LAST_C;
         default:      last_idx = LAST_D;
      endcase
   end

endmodule

// File: rtl/lc_pattern_seq.sv
module lc_pattern_seq #(
   parameter int unsigned CODE_W = 16,
   localparam int unsigned IDX_W = $clog2(CODE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              tx_enable,
   input  logic [CODE_W-1:0] code_live,
   input  logic [IDX_W-1:0]  last_live,
   output logic              pat_bit,
   output logic              run_q,
   output logic [IDX_W-1:0]  idx_q,
   output logic [IDX_W-1:0]  last_q
);

   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] cur_code;
   logic [IDX_W-1:0]  cur_last;
   logic [IDX_W-1:0]  cur_pos;
   logic [CODE_W-1:0] code_rev;
   logic              at_wrap;

   // A new burst takes live settings; a running one keeps its shadow copy.
   always_comb begin
      cur_code = run_q ? code_q : code_live;
      cur_last = run_q ? last_q : last_live;
      cur_pos  = run_q ? idx_q  : '0;
      at_wrap  = (cur_pos == cur_last);
   end

   // Reverse so that position 0 selects the code MSB.
   for (genvar gi = 0; gi < CODE_W; gi++) begin : g_rev
      assign code_rev[gi] = cur_code[CODE_W-1-gi];
   end

   assign pat_bit = code_rev[cur_pos];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         idx_q  <= '0;
         last_q <= '0;
         code_q <= '0;
      end else if (bit_en) begin
         if (!tx_enable) begin
            run_q <= 1'b0;
            idx_q <= '0;
         end else begin
            run_q <= 1'b1;
            if (at_wrap) begin
               idx_q  <= '0;
               code_q <= code_live;
               last_q <= last_live;
            end else begin
               idx_q  <= cur_pos + 1'b1;
               code_q <= cur_code;
               last_q <= cur_last;
            end
         end
      end
   end

endmodule

// File: rtl/lc_out_stage.sv
module lc_out_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic sel_pattern,
   input  logic pat_bit,
   input  logic bypass_in,
   output logic tx_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tx_out <= 1'b0;
      else if (bit_en) tx_out <= sel_pattern ? pat_bit : bypass_in;
   end

endmodule

// File: rtl/lc_loop_code_gen.sv
module lc_loop_code_gen
   import lc_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned LEN_A  = 5,
   parameter int unsigned LEN_B  = 6,
   parameter int unsigned LEN_C  = 7,
   parameter int unsigned LEN_D  = 16,
   localparam int unsigned CODE_W = 2 * BYTE_W,
   localparam int unsigned IDX_W  = $clog2(CODE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              tx_enable,
   input  logic [BYTE_W-1:0] code_hi,
   input  logic [BYTE_W-1:0] code_lo,
   input  logic [SEL_W-1:0]  len_sel,
   input  logic              bypass_in,
   output logic              tx_out
);

   localparam int unsigned LENS [4] = '{LEN_A, LEN_B, LEN_C, LEN_D};

   for (genvar gl = 0; gl < 4; gl++) begin : g_len_chk
      if (LENS[gl] < 1 || LENS[gl] > CODE_W) begin : g_bad
         $error("pattern length out of range for code width");
      end
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("byte width must be positive");
   end

   logic [CODE_W-1:0] code_live;
   logic [IDX_W-1:0]  last_live;
   logic              pat_bit;
   logic              seq_run;
   logic [IDX_W-1:0]  seq_idx;
   logic [IDX_W-1:0]  seq_last;

   assign code_live = {code_hi, code_lo};

   lc_len_decode #(
      .CODE_W(CODE_W), .LEN_A(LEN_A), .LEN_B(LEN_B), .LEN_C(LEN_C), .LEN_D(LEN_D)
   ) dec_i (
      .sel      (len_sel),
      .last_idx (last_live)
   );

   lc_pattern_seq #(.CODE_W(CODE_W)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .tx_enable (tx_enable),
      .code_live (code_live),
      .last_live (last_live),
      .pat_bit   (pat_bit),
      .run_q     (seq_run),
      .idx_q     (seq_idx),
      .last_q    (seq_last)
   );

   lc_out_stage out_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .sel_pattern (tx_enable),
      .pat_bit     (pat_bit),
      .bypass_in   (bypass_in),
      .tx_out      (tx_out)
   );

endmodule

// File: rtl/lc_gen_chk.sv
module lc_gen_chk #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned IDX_W = $clog2(2 * BYTE_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic              tx_enable,
   input logic [BYTE_W-1:0] code_hi,
   input logic              bypass_in,
   input logic              tx_out,
   input logic              seq_run,
   input logic [IDX_W-1:0]  seq_idx,
   input logic [IDX_W-1:0]  seq_last
);

   logic en_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_seen <= 1'b0;
      else if (bit_en) en_seen <= tx_enable;
   end

   AST_HOLD_NO_BIT_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_out)); // R6

   AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && !tx_enable |=> tx_out == $past(bypass_in)); // R9

   AST_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && tx_enable && !en_seen |=> tx_out == $past(code_hi[BYTE_W-1])); // R7

   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_run |-> seq_idx <= seq_last); // R8

   AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && !tx_enable |=> !seq_run); // R10

endmodule

bind lc_loop_code_gen lc_gen_chk #(.BYTE_W(BYTE_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_en    (bit_en),
   .tx_enable (tx_enable),
   .code_hi   (code_hi),
   .bypass_in (bypass_in),
   .tx_out    (tx_out),
   .seq_run   (seq_run),
   .seq_idx   (seq_idx),
   .seq_last  (seq_last)
);

// File: tb/lc_loop_code_gen_tb_top.sv
`timescale 1ns/1ps
module lc_loop_code_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       tx_enable = 1'b0;
   logic [7:0] code_hi = 8'h00;
   logic [7:0] code_lo = 8'h00;
   logic [1:0] len_sel = 2'b00;
   logic       bypass_in = 1'b0;
   logic       tx_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state
   bit        m_run = 1'b0;
   int        m_pos = 0;
   int        m_last = 0;
   bit [15:0] m_code = '0;
   bit        m_out = 1'b0;

   always #2.5 clk = ~clk;

   lc_loop_code_gen dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
      .code_hi(code_hi), .code_lo(code_lo), .len_sel(len_sel),
      .bypass_in(bypass_in), .tx_out(tx_out)
   );

   function automatic int len_of(input logic [1:0] s);
      case (s)
         2'b00:   return 5;
         2'b01:   return 6;
         2'b10:   return 7;
         default: return 16;
      endcase
   endfunction

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: tx_out actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // Advance the model for one cycle with the inputs now applied.
   task automatic model_step();
      bit [15:0] c;
      int l, p;
      if (!bit_en) return;
      if (!tx_enable) begin
         m_out = bypass_in; m_run = 0; m_pos = 0;
         return;
      end
      c = m_run ? m_code : {code_hi, code_lo};
      l = m_run ? m_last : len_of(len_sel) - 1;
      p = m_run ? m_pos : 0;
      m_out = c[15-p];
      if (p == l) begin
         m_pos = 0; m_code = {code_hi, code_lo}; m_last = len_of(len_sel) - 1;
      end else begin
         m_pos = p + 1; m_code = c; m_last = l;
      end
      m_run = 1;
   endtask

   task automatic step(input logic be, input logic en, input logic byp, input string tag);
      bit_en = be; tx_enable = en; bypass_in = byp;
      model_step();
      @(posedge clk);
      @(negedge clk);
      check(tx_out, m_out, tag);
   endtask

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_2148));
      repeat (3) @(negedge clk);
      check(tx_out, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_out, 1'b0, "R1 after reset");

      // R3: 0x80 length 5 gives 10000 repeated
      code_hi = 8'h80; code_lo = 8'h00; len_sel = 2'b00;
      for (int i = 0; i < 20; i++) begin
         step(1, 1, 0, "R3 model");
         check(tx_out, (i % 5) == 0, "R3 literal 10000");
      end
      step(1, 0, 0, "R9 end burst");

      // R5: full 16-bit walk
      code_hi = 8'hA7; code_lo = 8'h3C; len_sel = 2'b11;
      for (int i = 0; i < 32; i++) begin
         logic [15:0] w;
         w = 16'hA73C;
         step(1, 1, 0, "R5 model");
         check(tx_out, w[15 - (i % 16)], "R5 literal walk");
      end
      step(1, 0, 1, "R9 end burst");

      // R4: length 7 with lower byte changing every bit
      code_hi = 8'h6D; len_sel = 2'b10;
      for (int i = 0; i < 28; i++) begin
         code_lo = 8'($urandom);
         step(1, 1, 0, "R4 model");
         check(tx_out, code_hi[7 - (i % 7)], "R4 low byte ignored");
      end
      step(1, 0, 0, "R9 end burst");

      // R2: each length select, period from a single marker bit
      for (int s = 0; s < 4; s++) begin
         len_sel = 2'(s); code_hi = 8'h80; code_lo = 8'h00;
         for (int i = 0; i < 2 * len_of(2'(s)); i++) begin
            step(1, 1, 0, "R2 model");
            check(tx_out, (i % len_of(2'(s))) == 0, "R2 period");
         end
         step(1, 0, 0, "R9 end burst");
      end

      // R6: gaps in bit_en hold the output
      code_hi = 8'hB5; code_lo = 8'h91; len_sel = 2'b11;
      for (int i = 0; i < 60; i++)
         step(($urandom % 3) == 0, 1, 0, "R6 hold between enables");

      // R10 then R7: drop mid-pattern, re-enable restarts at bit 0
      step(1, 0, 1, "R10 drop to bypass");
      step(1, 0, 0, "R9 bypass");
      code_hi = 8'h40;
      step(1, 1, 1, "R7 model");
      check(tx_out, 1'b0, "R7 first bit is code_hi[7]");
      code_hi = 8'hC0;
      step(1, 1, 0, "R7 second bit from shadow");

      // R8: changes mid-pattern, including on the wrap bit
      for (int i = 0; i < 400; i++) begin
         if (($urandom % 4) == 0) begin
            code_hi = 8'($urandom); code_lo = 8'($urandom); len_sel = 2'($urandom);
         end
         step(($urandom % 4) != 0, 1, 0, "R8 change at boundary");
      end

      // R9 random bypass data
      for (int i = 0; i < 100; i++)
         step(($urandom % 2) == 0, 0, 1'($urandom), "R9 bypass latency");

      // mixed random
      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 8) == 0) begin
            code_hi = 8'($urandom); code_lo = 8'($urandom); len_sel = 2'($urandom);
         end
         step(($urandom % 3) != 0, ($urandom % 16) != 0, 1'($urandom), "R10 mixed");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule